// File: doc/BRIEF.md
# Decode-Stage Operand Bypass

This block resolves the two source operands of the instruction sitting in the fetch/decode phase of a short in-order pipeline. The phases are fetch/decode, ALU, memory and writeback. Each source register index is compared against the destination index and write enable of the two instructions ahead of it, in the ALU and memory phases. The operand value then comes from one of three places: the register file read port, the ALU-phase result, or the memory-phase result. A writing instruction in the memory phase offers its load data when it is a load, and its carried ALU result otherwise.

The register file commits on the opposite clock edge from the pipeline registers. An instruction three slots behind its producer therefore reads a correct value, and no writeback-phase path exists. A load followed immediately by a consumer is neither detected nor stalled. Software places one instruction between them, and the memory-phase path then covers the dependency.

The block is purely combinational. Besides the two operand values, it reports a 2-bit select code per operand so that the chosen path can be observed.

Top module: `decode_bypass`

## Requirements
- R1: When the ALU-phase write enable is high and the ALU-phase destination equals a nonzero source index, that operand takes the ALU-phase result and its select code is 01.
- R2: When the memory-phase write enable is high and its destination equals a nonzero source index, and R1 does not apply to that operand, the operand takes the memory-phase value and its select code is 10.
- R3: When both the ALU phase and the memory phase write the same nonzero source register, the ALU-phase value is chosen (select 01).
- R4: The memory-phase value is the load data when the memory-phase load flag is 1, and the carried ALU result when the flag is 0.
- R5: With no match, an operand takes its register-file read value and its select code is 00.
- R6: A phase whose write enable is low never produces a match, even if its destination index equals the source index.
- R7: A source index of 0 yields an operand of zero and select 00, whatever any in-flight destination or the register-file read value is.
- R8: The ALU-phase path always delivers the ALU-phase result. Load data reaches an operand only through the memory-phase path, so a load needs one intervening instruction before a consumer.
- R9: The two operands resolve independently: in one cycle each may take a different path.
- R10: No writeback-phase path exists. In a program run against a reference register model, every operand equals the architectural value when the register file holds every result three or more slots old.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| decSrcA | input | REG_AW | First source register index of the decode-phase instruction |
| decSrcB | input | REG_AW | Second source register index of the decode-phase instruction |
| rfDataA | input | DATA_W | Register file read value for decSrcA |
| rfDataB | input | DATA_W | Register file read value for decSrcB |
| exeDst | input | REG_AW | Destination index of the ALU-phase instruction |
| exeWe | input | 1 | Register write enable of the ALU-phase instruction |
| exeResult | input | DATA_W | ALU output of the ALU-phase instruction |
| memDst | input | REG_AW | Destination index of the memory-phase instruction |
| memWe | input | 1 | Register write enable of the memory-phase instruction |
| memToReg | input | 1 | 1 when the memory-phase instruction is a load |
| memAluResult | input | DATA_W | ALU result carried in the memory phase |
| memLoadData | input | DATA_W | Data read by a load in the memory phase |
| opA | output | DATA_W | Resolved first operand |
| opB | output | DATA_W | Resolved second operand |
| selA | output | 2 | Path of opA: 00 register file, 01 ALU phase, 10 memory phase |
| selB | output | 2 | Path of opB, same encoding |

## Verification
Two things can coincide in one cycle. Both older phases can match the same source register, which tests the priority of the younger instruction. The two operands can also take different paths at once, one from the ALU phase and the other from the memory phase. The vector table provokes both on purpose. It judges each operand's select code against a hand-written expectation, and each operand value against the constant placed on the chosen path. A short program, whose reference register model is updated in program order, produces the same collisions naturally, including back-to-back writers of one register and a write aimed at register 0.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  localparam int NUM_SRC = 2;

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_ALU = 2'b01,
    SEL_MEM = 2'b10
  } selCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_SRC-1:0][1:0] pick;
    logic [NUM_SRC-1:0]      forceZero;
    logic                    memUseLoad;
  } fwdStrobes_t;

endpackage

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
  import fwd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [NUM_SRC-1:0][REG_AW-1:0] srcIdx,
  input  logic [REG_AW-1:0]              exeDst,
  input  logic                           exeWe,
  input  logic [REG_AW-1:0]              memDst,
  input  logic                           memWe,
  input  logic                           memToReg,
  output fwdStrobes_t                    strobes
);

  logic [NUM_SRC-1:0]      isZero;
  logic [NUM_SRC-1:0]      hitExe;
  logic [NUM_SRC-1:0]      hitMem;
  logic [NUM_SRC-1:0][1:0] pickVec;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign isZero[i] = (srcIdx[i] == '0);
    assign hitExe[i] = exeWe && (exeDst == srcIdx[i]) && !isZero[i];
    assign hitMem[i] = memWe && (memDst == srcIdx[i]) && !isZero[i];
    // younger instruction (ALU phase) wins
    assign pickVec[i] = hitExe[i] ? SEL_ALU :
                        hitMem[i] ? SEL_MEM : SEL_RF;

    always_comb begin
      assert_bubble_R6: assert (exeWe || memWe || pickVec[i] == SEL_RF)
        else $error("bypass chosen with both write enables low");
      assert_reg0_R7: assert (srcIdx[i] != '0 || pickVec[i] == SEL_RF)
        else $error("register 0 bypassed");
      assert_priority_R3: assert (!(exeWe && memWe && exeDst == memDst &&
                                    exeDst == srcIdx[i] && srcIdx[i] != '0) ||
                                  pickVec[i] == SEL_ALU)
        else $error("older memory-phase value chosen over ALU phase");
    end
  end

  assign strobes = '{pick: pickVec, forceZero: isZero, memUseLoad: memToReg};

endmodule

// File: rtl/fwd_datapath.sv
module fwd_datapath
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwdStrobes_t                    strobes,
  input  logic [NUM_SRC-1:0][DATA_W-1:0] rfData,
  input  logic [DATA_W-1:0]              exeResult,
  input  logic [DATA_W-1:0]              memAluResult,
  input  logic [DATA_W-1:0]              memLoadData,
  output logic [NUM_SRC-1:0][DATA_W-1:0] operand
);

  logic [DATA_W-1:0] memValue;

  assign memValue = strobes.memUseLoad ? memLoadData : memAluResult;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_mux
    always_comb begin
      if (strobes.forceZero[i]) begin
        operand[i] = '0;
      end else begin
        unique case (strobes.pick[i])
          SEL_ALU: operand[i] = exeResult;
          SEL_MEM: operand[i] = memValue;
          default: operand[i] = rfData[i];
        endcase
      end
    end

    always_comb begin
      assert_alu_path_R1: assert (strobes.pick[i] != SEL_ALU || operand[i] == exeResult)
        else $error("ALU path does not deliver ALU result");
      assert_mem_value_R4: assert (strobes.pick[i] != SEL_MEM ||
                                   operand[i] == (strobes.memUseLoad ? memLoadData
                                                                     : memAluResult))
        else $error("memory path delivers wrong value");
      assert_zero_R7: assert (!strobes.forceZero[i] || operand[i] == '0)
        else $error("register 0 operand not zero");
    end
  end

endmodule

// File: rtl/decode_bypass.sv
module decode_bypass
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] decSrcA,
  input  logic [REG_AW-1:0] decSrcB,
  input  logic [DATA_W-1:0] rfDataA,
  input  logic [DATA_W-1:0] rfDataB,
  input  logic [REG_AW-1:0] exeDst,
  input  logic              exeWe,
  input  logic [DATA_W-1:0] exeResult,
  input  logic [REG_AW-1:0] memDst,
  input  logic              memWe,
  input  logic              memToReg,
  input  logic [DATA_W-1:0] memAluResult,
  input  logic [DATA_W-1:0] memLoadData,
  output logic [DATA_W-1:0] opA,
  output logic [DATA_W-1:0] opB,
  output logic [1:0]        selA,
  output logic [1:0]        selB
);

  fwdStrobes_t                    strobes;
  logic [NUM_SRC-1:0][REG_AW-1:0] srcIdx;
  logic [NUM_SRC-1:0][DATA_W-1:0] rfData;
  logic [NUM_SRC-1:0][DATA_W-1:0] operand;

  assign srcIdx = {decSrcB, decSrcA};
  assign rfData = {rfDataB, rfDataA};

  fwd_ctrl #(.REG_AW(REG_AW)) u_ctrl (
    .srcIdx  (srcIdx),
    .exeDst  (exeDst),
    .exeWe   (exeWe),
    .memDst  (memDst),
    .memWe   (memWe),
    .memToReg(memToReg),
    .strobes (strobes)
  );

  fwd_datapath #(.DATA_W(DATA_W)) u_dp (
    .strobes     (strobes),
    .rfData      (rfData),
    .exeResult   (exeResult),
    .memAluResult(memAluResult),
    .memLoadData (memLoadData),
    .operand     (operand)
  );

  assign opA  = operand[0];
  assign opB  = operand[1];
  assign selA = strobes.pick[0];
  assign selB = strobes.pick[1];

endmodule

// File: tb/decode_bypass_test.sv
`timescale 1ns/1ps
module decode_bypass_test;

  localparam logic [31:0] EXE_V  = 32'h1111_1111;
  localparam logic [31:0] MALU_V = 32'h2222_2222;
  localparam logic [31:0] LOAD_V = 32'h3333_3333;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [4:0]  decSrcA, decSrcB, exeDst, memDst;
  logic        exeWe, memWe, memToReg;
  logic [31:0] rfDataA, rfDataB, exeResult, memAluResult, memLoadData;
  logic [31:0] opA, opB;
  logic [1:0]  selA, selB;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  decode_bypass uut (
    .decSrcA(decSrcA), .decSrcB(decSrcB), .rfDataA(rfDataA), .rfDataB(rfDataB),
    .exeDst(exeDst), .exeWe(exeWe), .exeResult(exeResult),
    .memDst(memDst), .memWe(memWe), .memToReg(memToReg),
    .memAluResult(memAluResult), .memLoadData(memLoadData),
    .opA(opA), .opB(opB), .selA(selA), .selB(selB)
  );

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // sA sB eD eW mD mW mL expSelA expSelB
  typedef struct packed {
    logic [4:0] sA; logic [4:0] sB; logic [4:0] eD; logic eW;
    logic [4:0] mD; logic mW; logic mL; logic [1:0] xA; logic [1:0] xB;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{5'd1,  5'd2,  5'd3,  1'b1, 5'd4,  1'b1, 1'b0, 2'b00, 2'b00}, // R5
    '{5'd3,  5'd2,  5'd3,  1'b1, 5'd4,  1'b1, 1'b0, 2'b01, 2'b00}, // R1
    '{5'd4,  5'd3,  5'd3,  1'b0, 5'd4,  1'b1, 1'b0, 2'b10, 2'b00}, // R2 R6
    '{5'd4,  5'd4,  5'd4,  1'b1, 5'd4,  1'b1, 1'b1, 2'b01, 2'b01}, // R3
    '{5'd5,  5'd6,  5'd6,  1'b1, 5'd5,  1'b1, 1'b1, 2'b10, 2'b01}, // R9 R4 load
    '{5'd5,  5'd6,  5'd6,  1'b1, 5'd5,  1'b1, 1'b0, 2'b10, 2'b01}, // R4 alu
    '{5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 1'b1, 2'b00, 2'b00}, // R7
    '{5'd7,  5'd7,  5'd7,  1'b0, 5'd7,  1'b0, 1'b1, 2'b00, 2'b00}, // R6
    '{5'd31, 5'd0,  5'd31, 1'b1, 5'd0,  1'b1, 1'b0, 2'b01, 2'b00}, // R7 R8
    '{5'd2,  5'd31, 5'd2,  1'b0, 5'd31, 1'b1, 1'b1, 2'b00, 2'b10}  // R9
  };

  function automatic logic [31:0] expVal(input logic [4:0] src, input logic [1:0] sel,
                                         input logic [31:0] rf, input logic ld);
    if (src == 5'd0) return 32'h0;
    case (sel)
      2'b01:   return EXE_V;
      2'b10:   return ld ? LOAD_V : MALU_V;
      default: return rf;
    endcase
  endfunction

  // program for the reference-model run
  typedef struct packed {
    logic [2:0] dst; logic we; logic ld; logic [2:0] a; logic [2:0] b;
  } ins_t;

  localparam ins_t PROG [13] = '{
    '{3'd1, 1'b1, 1'b0, 3'd2, 3'd3},
    '{3'd4, 1'b1, 1'b0, 3'd3, 3'd1},  // ALU-phase hit on r1
    '{3'd4, 1'b1, 1'b0, 3'd3, 3'd1},  // memory-phase hit on r1
    '{3'd4, 1'b1, 1'b0, 3'd3, 3'd1},  // register file holds r1
    '{3'd5, 1'b1, 1'b1, 3'd0, 3'd0},  // load r5
    '{3'd5, 1'b0, 1'b0, 3'd0, 3'd0},  // nop naming r5
    '{3'd6, 1'b1, 1'b0, 3'd5, 3'd4},  // load data via memory phase
    '{3'd5, 1'b1, 1'b0, 3'd6, 3'd6},
    '{3'd5, 1'b1, 1'b0, 3'd5, 3'd6},
    '{3'd0, 1'b1, 1'b0, 3'd5, 3'd5},  // write aimed at r0
    '{3'd7, 1'b1, 1'b0, 3'd0, 3'd0},
    '{3'd7, 1'b1, 1'b0, 3'd0, 3'd7},
    '{3'd7, 1'b1, 1'b0, 3'd7, 3'd1}   // both phases write r7
  };

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] arch [8];
    logic [31:0] comm [8];
    logic [2:0]  eD, mD;
    logic        eW, eL, mW, mL;
    logic [31:0] eRes, mRes, res;

    decSrcA = '0; decSrcB = '0; rfDataA = '0; rfDataB = '0;
    exeDst = '0; exeWe = 1'b0; exeResult = '0;
    memDst = '0; memWe = 1'b0; memToReg = 1'b0; memAluResult = '0; memLoadData = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // idle state after reset
    @(negedge clk); #1;
    check32("R5 idle opA", opA, 32'h0);
    check32("R5 idle selA", {30'h0, selA}, 32'h0);
    check32("R5 idle selB", {30'h0, selB}, 32'h0);

    // vector table
    foreach (VECS[k]) begin
      @(negedge clk);
      decSrcA = VECS[k].sA; decSrcB = VECS[k].sB;
      rfDataA = 32'hA000_0000 | 32'(VECS[k].sA) | 32'h0100_0000;
      rfDataB = 32'hB000_0000 | 32'(VECS[k].sB) | 32'h0100_0000;
      exeDst = VECS[k].eD; exeWe = VECS[k].eW; exeResult = EXE_V;
      memDst = VECS[k].mD; memWe = VECS[k].mW; memToReg = VECS[k].mL;
      memAluResult = MALU_V; memLoadData = LOAD_V;
      #1;
      check32($sformatf("R1 R2 R3 R7 R9 vec%0d selA", k), {30'h0, selA}, {30'h0, VECS[k].xA});
      check32($sformatf("R1 R2 R3 R7 R9 vec%0d selB", k), {30'h0, selB}, {30'h0, VECS[k].xB});
      check32($sformatf("R4 R5 R8 vec%0d opA", k), opA,
              expVal(VECS[k].sA, VECS[k].xA, rfDataA, VECS[k].mL));
      check32($sformatf("R4 R5 R8 vec%0d opB", k), opB,
              expVal(VECS[k].sB, VECS[k].xB, rfDataB, VECS[k].mL));
    end

    // R6: equal destinations but both enables low leave register-file values
    @(negedge clk);
    decSrcA = 5'd9; decSrcB = 5'd9; rfDataA = 32'h0909_0909; rfDataB = 32'h9090_9090;
    exeDst = 5'd9; exeWe = 1'b0; memDst = 5'd9; memWe = 1'b0;
    #1;
    check32("R6 bubble opA", opA, 32'h0909_0909);
    check32("R6 bubble opB", opB, 32'h9090_9090);

    // program run against reference register model (R10)
    for (int r = 0; r < 8; r++) begin
      arch[r] = (r == 0) ? 32'h0 : 32'(r) * 32'h100;
      comm[r] = arch[r];
    end
    eD = '0; eW = 1'b0; eL = 1'b0; eRes = '0;
    mD = '0; mW = 1'b0; mL = 1'b0; mRes = '0;
    for (int s = 0; s < 13; s++) begin
      @(negedge clk);
      decSrcA = 5'(PROG[s].a); decSrcB = 5'(PROG[s].b);
      rfDataA = (PROG[s].a == 0) ? 32'hFFFF_FFFF : comm[PROG[s].a];
      rfDataB = (PROG[s].b == 0) ? 32'hFFFF_FFFF : comm[PROG[s].b];
      exeDst = 5'(eD); exeWe = eW;
      exeResult = eL ? 32'hADD0_0000 : eRes;
      memDst = 5'(mD); memWe = mW; memToReg = mL;
      memAluResult = mL ? 32'hADD0_0000 : mRes;
      memLoadData  = mL ? mRes : 32'hDEAD_BEEF;
      #1;
      check32($sformatf("R10 step%0d opA", s), opA, arch[PROG[s].a]);
      check32($sformatf("R10 step%0d opB", s), opB, arch[PROG[s].b]);
      res = PROG[s].ld ? (32'h5EED_0000 + 32'(s))
                       : arch[PROG[s].a] + arch[PROG[s].b] + 32'(s) + 32'd1;
      // falling-edge commit of the instruction leaving the memory phase
      if (mW && mD != 0) comm[mD] = mRes;
      mD = eD; mW = eW; mL = eL; mRes = eRes;
      eD = PROG[s].dst; eW = PROG[s].we; eL = PROG[s].ld; eRes = res;
      if (PROG[s].we && PROG[s].dst != 0) arch[PROG[s].dst] = res;
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule